// File: doc/BRIEF.md
# ROM-Sequenced Accumulator Core

This block is a small self-running execution core. A program counter walks a fixed 16-word instruction store. Each 8-bit word is decoded into an ALU operation, a destination-register select and a 4-bit unsigned immediate. The ALU combines the selected working register with the immediate. The low byte of the result goes back into that register, and the full 16-bit result is reported. A controller paces every instruction through five phases: idle, fetch, execute, send and wait. The program counter moves on only after the downstream serializer has finished with the previous result. The built-in program adds 3, subtracts 2, multiplies by 5, does nothing, and then starts over.

A mode input chooses what feeds the shared ALU. When the core is selected, the ALU takes its operands from the decoded instruction. When the manual path is selected, it takes two 4-bit operands and a 3-bit operation straight from input pins, and the parallel result output follows them combinationally. Each executed result is offered on a valid/ready stream to an external serializer. The serializer accepts a word with `res_ready`, raises `tx_busy` in the cycle after it accepts, and holds it until the frame has left (for example 8N1 at 9600 bps from a 12 MHz clock). A serializer that finishes at once may leave `tx_busy` low. Back-pressure is lossless: an offered word waits, unchanged, for as long as `res_ready` is low.

Top module: `acc_seq_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `result` reads 0, `res_valid` reads 0 and `link_busy` reads 0. Both registers and the program counter start at zero.
- R2: An instruction word holds the operation in bits [7:5], the destination select in bit 4 (0 = R0, 1 = R1) and the immediate in bits [3:0]. With `PROG_SEL`=0, entries 0..3 are 0x03, 0x22, 0x45 and 0x60. After entry `PROG_LEN-1` the counter wraps to 0. The results reported from reset are therefore 3, 1, 5, 5, 8, 6, 30, 30, 33, ...
- R3: Operation codes are 0 add, 1 subtract (16-bit wrap), 2 multiply, 3 divide, 4 remainder, 5 equal, 6 greater-than and 7 less-than. Comparisons give 1 or 0. Dividing by zero gives 0x00FF, and a remainder by zero gives the dividend.
- R4: Only the low 8 bits of a result are written back into the destination register, while the full 16 bits are reported. In the default program, 156*5 is reported as 0x030C and the register keeps 0x0C.
- R5: Operation 3 with a zero immediate is a no-op. It leaves both registers unchanged and reports the current value of the selected register.
- R6: Every executed instruction produces exactly one stream transfer. While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays unchanged.
- R7: After a transfer, the program counter advances only in a cycle where `tx_busy` is sampled low. The next `res_valid` rises exactly three cycles after that cycle, so `tx_busy` has been low for at least three cycles before every new offer.
- R8: When `ena` or `mode_cpu` drops, the instruction in progress completes, including its transfer, and no further instruction starts. Raising both again resumes with the next instruction and with the register contents preserved.
- R9: With `mode_cpu`=0 and the sequencer idle, `result` equals the R3 operation selected by `man_op`, applied to the zero-extended `man_a` and `man_b`, with no clock edge needed. While `mode_cpu`=1, the manual pins have no effect on any output.
- R10: With `mode_cpu`=1, `result` shows the most recently executed result (0 before the first one) and equals `res_data` while `res_valid` is high.
- R11: `link_busy` is high exactly when `res_valid` or `tx_busy` is high.
- R12: With `PROG_SEL`=1, entry i holds operation i mod 8, destination bit (i >= 8) and immediate (i+1) mod 16. The counter then wraps only after entry `ROM_DEPTH-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ena | input | 1 | Allows new instructions to start when high |
| mode_cpu | input | 1 | 1 selects the internal core, 0 selects the manual pins |
| man_a | input | 4 | Manual first operand |
| man_b | input | 4 | Manual second operand |
| man_op | input | 3 | Manual operation code (R3 map) |
| result | output | 16 | Parallel result |
| link_busy | output | 1 | High while a result is pending or being serialised |
| res_valid | output | 1 | Stream word offered |
| res_data | output | 16 | Stream word: the executed result |
| res_ready | input | 1 | Serializer accepts the word |
| tx_busy | input | 1 | Serializer is shifting out a frame |

## Verification
The bench builds two copies side by side. The first uses the defaults (`PROG_SEL`=0, `PROG_LEN`=4, `ROM_DEPTH`=16) and faces a responder whose ready delay and busy length change between phases. That reaches lossless back-pressure, the busy gate, pausing through enable and mode, and the 16-bit product that overflows the register. The second uses `PROG_SEL`=1 with an always-ready, never-busy serializer. It reaches register R1, every operation code, the shortest four-cycle step and the wrap at the end of the full store.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int INSTR_W = 8;
  localparam int OP_W    = 3;
  localparam int IMM_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_MOD = 3'd4,
    OP_EQ  = 3'd5,
    OP_GT  = 3'd6,
    OP_LT  = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_SEND,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    alu_op_e          op;
    logic             dst;
    logic [IMM_W-1:0] imm;
    logic             nop;
  } dec_t;

  // Program store contents, computed from the selected program and the index.
  function automatic logic [INSTR_W-1:0] rom_word(input int sel, input int idx);
    logic [3:0] i4;
    i4 = 4'(idx);
    if (sel == 0) begin
      case (idx)
        0:       return 8'h03;  // add R0, 3
        1:       return 8'h22;  // sub R0, 2
        2:       return 8'h45;  // mul R0, 5
        default: return 8'h60;  // no-op
      endcase
    end
    return {i4[2:0], i4[3], i4 + 4'd1};
  endfunction

endpackage

// File: rtl/seq_rom.sv
module seq_rom
  import acc_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int PROG_SEL = 0,
  parameter int PROG_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  output logic [INSTR_W-1:0] instr_o
);

  localparam int PC_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LAST = ((PROG_SEL != 0) ? DEPTH : PROG_LEN) - 1;

  logic [INSTR_W-1:0] store [DEPTH];
  logic [PC_W-1:0]    pc_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign store[g] = rom_word(PROG_SEL, g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (step_i) begin
      pc_q <= (pc_q == PC_W'(LAST)) ? '0 : pc_q + 1'b1;
    end
  end

  assign instr_o = store[pc_q];

endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import acc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);

  always_comb begin
    dec_o.op  = alu_op_e'(instr_i[7:5]);
    dec_o.dst = instr_i[4];
    dec_o.imm = instr_i[IMM_W-1:0];
    // divide by a zero immediate is the reserved no-op encoding
    dec_o.nop = (instr_i[7:5] == OP_DIV) && (instr_i[IMM_W-1:0] == '0);
  end

endmodule

// File: rtl/seq_regs.sv
module seq_regs #(
  parameter int W    = 8,
  parameter int NREG = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wsel,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] rsel,
  output logic [W-1:0]            rdata
);

  localparam int SEL_W = $clog2(NREG);

  logic [W-1:0] bank [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we && (wsel == SEL_W'(i))) bank[i] <= wdata;
      end
    end
  end

  assign rdata = bank[rsel];

endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  alu_op_e        op,
  output logic [2*W-1:0] y
);

  localparam int RW = 2 * W;

  logic [RW-1:0] ax, bx;

  always_comb begin
    ax = {{W{1'b0}}, a};
    bx = {{W{1'b0}}, b};
    case (op)
      OP_ADD:  y = ax + bx;
      OP_SUB:  y = ax - bx;
      OP_MUL:  y = ax * bx;
      OP_DIV:  y = (b == '0) ? {{W{1'b0}}, {W{1'b1}}} : ax / bx;
      OP_MOD:  y = (b == '0) ? ax : ax % bx;
      OP_EQ:   y = {{(RW-1){1'b0}}, a == b};
      OP_GT:   y = {{(RW-1){1'b0}}, a > b};
      OP_LT:   y = {{(RW-1){1'b0}}, a < b};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int ROM_DEPTH = 16,
  parameter int PROG_SEL  = 0,
  parameter int PROG_LEN  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ena,
  input  logic                mode_cpu,
  input  logic [3:0]          man_a,
  input  logic [3:0]          man_b,
  input  logic [2:0]          man_op,
  output logic [2*WORD_W-1:0] result,
  output logic                link_busy,
  output logic                res_valid,
  output logic [2*WORD_W-1:0] res_data,
  input  logic                res_ready,
  input  logic                tx_busy
);

  localparam int RES_W = 2 * WORD_W;
  localparam int PAD_W = WORD_W - IMM_W;

  seq_state_e         st_q, st_d;
  logic               run_ok, step;
  logic [INSTR_W-1:0] instr, ir_q;
  dec_t               dec;
  logic               sel_core, reg_we;
  logic [WORD_W-1:0]  reg_rd, alu_a, alu_b;
  alu_op_e            alu_op;
  logic [RES_W-1:0]   alu_y, result_q;

  assign run_ok = ena & mode_cpu;
  assign step   = (st_q == ST_WAIT) && !tx_busy;

  // sequencing controller
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (run_ok) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_EXEC;
      ST_EXEC:  st_d = ST_SEND;
      ST_SEND:  if (res_ready) st_d = ST_WAIT;
      ST_WAIT:  if (!tx_busy) st_d = run_ok ? ST_FETCH : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ir_q     <= '0;
      result_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_FETCH) ir_q <= instr;
      if (st_q == ST_EXEC) result_q <= dec.nop ? {{WORD_W{1'b0}}, reg_rd} : alu_y;
    end
  end

  seq_rom #(
    .DEPTH   (ROM_DEPTH),
    .PROG_SEL(PROG_SEL),
    .PROG_LEN(PROG_LEN)
  ) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step),
    .instr_o(instr)
  );

  seq_decode u_dec (
    .instr_i(ir_q),
    .dec_o  (dec)
  );

  assign reg_we = (st_q == ST_EXEC) && !dec.nop;

  seq_regs #(
    .W   (WORD_W),
    .NREG(2)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .wsel (dec.dst),
    .wdata(alu_y[WORD_W-1:0]),
    .rsel (dec.dst),
    .rdata(reg_rd)
  );

  // operand source: the core owns the ALU in its execute cycle or in core mode
  assign sel_core = mode_cpu || (st_q == ST_EXEC);
  assign alu_a    = sel_core ? reg_rd : {{PAD_W{1'b0}}, man_a};
  assign alu_b    = sel_core ? {{PAD_W{1'b0}}, dec.imm} : {{PAD_W{1'b0}}, man_b};
  assign alu_op   = sel_core ? dec.op : alu_op_e'(man_op);

  seq_alu #(.W(WORD_W)) u_alu (
    .a (alu_a),
    .b (alu_b),
    .op(alu_op),
    .y (alu_y)
  );

  assign result    = mode_cpu ? result_q : alu_y;
  assign res_valid = (st_q == ST_SEND);
  assign res_data  = result_q;
  assign link_busy = res_valid | tx_busy;

endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ena,
  input logic             mode_cpu,
  input logic [RES_W-1:0] result,
  input logic             link_busy,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic             res_ready,
  input logic             tx_busy
);

  // R6: an offer not taken stays up with the same payload
  p_offer_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R7 / R8: a new offer follows a free serializer and an enabled core, three edges back
  p_gated_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> !$past(tx_busy, 3) && $past(ena && mode_cpu, 3));

  // R10: the parallel output carries the offered word in core mode
  p_parallel_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && mode_cpu |-> result == res_data);

  // R11: the busy flag covers a pending word and a running frame
  p_busy_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || tx_busy) |-> link_busy);

  p_busy_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid && !tx_busy |-> !link_busy);

endmodule

bind acc_seq_core acc_seq_core_chk #(.RES_W(2 * WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ena      (ena),
  .mode_cpu (mode_cpu),
  .result   (result),
  .link_busy(link_busy),
  .res_valid(res_valid),
  .res_data (res_data),
  .res_ready(res_ready),
  .tx_busy  (tx_busy)
);

// File: tb/acc_seq_core_test.sv
`timescale 1ns/1ps
module acc_seq_core_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, ena, mode_cpu;
  logic [3:0]  man_a, man_b;
  logic [2:0]  man_op;
  logic [15:0] result, res_data;
  logic        link_busy, res_valid, res_ready, tx_busy;

  logic [15:0] x_result, x_data;
  logic        x_busy, x_valid;

  acc_seq_core uut (
    .clk(clk), .rst_n(rst_n), .ena(ena), .mode_cpu(mode_cpu),
    .man_a(man_a), .man_b(man_b), .man_op(man_op),
    .result(result), .link_busy(link_busy), .res_valid(res_valid),
    .res_data(res_data), .res_ready(res_ready), .tx_busy(tx_busy)
  );

  acc_seq_core #(.PROG_SEL(1)) uut_ext (
    .clk(clk), .rst_n(rst_n), .ena(1'b1), .mode_cpu(1'b1),
    .man_a(4'h0), .man_b(4'h0), .man_op(3'h0),
    .result(x_result), .link_busy(x_busy), .res_valid(x_valid),
    .res_data(x_data), .res_ready(1'b1), .tx_busy(1'b0)
  );

  int checks = 0, fails = 0;
  int exp_q[$], ext_q[$];
  int got = 0, ext_got = 0;
  int ready_dly = 0, busy_len = 0, rdy_wait = 0, busy_cnt = 0, free_cnt = 0;
  bit prev_v = 0, prev_r = 0, done = 0;
  logic [15:0] prev_d = '0;
  logic hs = 0, x_hs = 0;
  logic [15:0] hs_data = '0, x_hs_data = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_op(input int op, input int a, input int b);
    case (op)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: return (a * b) & 16'hFFFF;
      3: return (b == 0) ? 255 : a / b;
      4: return (b == 0) ? a : a % b;
      5: return (a == b) ? 1 : 0;
      6: return (a > b) ? 1 : 0;
      default: return (a < b) ? 1 : 0;
    endcase
  endfunction

  task automatic build_refs();
    int r0, r1, v, op, imm, dst;
    int regs[2];
    r0 = 0;
    for (int k = 0; k < 64; k++) begin
      case (k % 4)
        0: begin v = ref_op(0, r0, 3); r0 = v & 255; end
        1: begin v = ref_op(1, r0, 2); r0 = v & 255; end
        2: begin v = ref_op(2, r0, 5); r0 = v & 255; end
        default: v = r0;
      endcase
      exp_q.push_back(v);
    end
    regs[0] = 0; regs[1] = 0; r1 = 0;
    for (int k = 0; k < 48; k++) begin
      op  = (k % 16) % 8;
      dst = ((k % 16) >= 8) ? 1 : 0;
      imm = ((k % 16) + 1) % 16;
      if (op == 3 && imm == 0) v = regs[dst];
      else begin v = ref_op(op, regs[dst], imm); regs[dst] = v & 255; end
      ext_q.push_back(v);
    end
    r1 = regs[1];
  endtask

  always @(posedge clk) begin
    hs        <= rst_n && res_valid && res_ready;
    hs_data   <= res_data;
    x_hs      <= rst_n && x_valid;
    x_hs_data <= x_data;
  end

  // reference comparison and serializer responder, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs) begin
        chk(got < exp_q.size() && hs_data == exp_q[got], "R2/R4/R5/R6 result stream",
            hs_data, (got < exp_q.size()) ? exp_q[got] : -1);
        got++;
        busy_cnt = busy_len;
        rdy_wait = 0;
      end
      if (x_hs && ext_got < ext_q.size()) begin
        chk(x_hs_data == ext_q[ext_got], "R12/R3 alternate program", x_hs_data, ext_q[ext_got]);
        ext_got++;
      end
      if (mode_cpu) begin
        if (res_valid) begin
          chk(result == res_data, "R10 parallel equals payload", result, res_data);
          chk(res_data == exp_q[got], "R2 offered word", res_data, exp_q[got]);
        end else begin
          chk(result == ((got == 0) ? 0 : exp_q[got-1]), "R9/R10 parallel holds last result",
              result, (got == 0) ? 0 : exp_q[got-1]);
        end
      end
      chk(link_busy == (res_valid || tx_busy), "R11 busy flag", link_busy, res_valid || tx_busy);
      if (prev_v && !prev_r)
        chk(res_valid && res_data == prev_d, "R6 offer held", {res_valid, res_data}, {1'b1, prev_d});
      if (res_valid && !prev_v)
        chk(free_cnt >= 3, "R7 advance after busy low", free_cnt, 3);
      tx_busy = (busy_cnt > 0);
      if (busy_cnt > 0) busy_cnt--;
      if (res_valid && !res_ready) begin
        if (rdy_wait >= ready_dly) res_ready = 1'b1;
        else rdy_wait++;
      end else if (!res_valid) begin
        res_ready = 1'b0;
        rdy_wait  = 0;
      end
      if (tx_busy || res_valid) free_cnt = 0;
      else free_cnt++;
      prev_v = res_valid;
      prev_r = res_ready;
      prev_d = res_data;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic manual(input int a, input int b, input int op, input int exp);
    man_a = 4'(a); man_b = 4'(b); man_op = 3'(op);
    #1;
    chk(result == exp, "R9/R3 manual result", result, exp);
    chk(res_valid == 1'b0, "R9 manual no offer", res_valid, 0);
  endtask

  initial begin
    int snap;
    build_refs();
    rst_n = 0; ena = 0; mode_cpu = 1; man_a = 0; man_b = 0; man_op = 0;
    res_ready = 0; tx_busy = 0;
    tick(3);
    chk(result == 0 && res_valid == 0 && link_busy == 0, "R1 during reset",
        {result, res_valid, link_busy}, 0);
    rst_n = 1;
    tick(1);
    chk(result == 0 && res_valid == 0 && link_busy == 0, "R1 after reset",
        {result, res_valid, link_busy}, 0);
    tick(10);
    chk(got == 0 && res_valid == 0, "R8 disabled core idles", got, 0);
    ena = 1;
    while (got < 6) tick(1);
    ready_dly = 3; busy_len = 5;
    man_a = 4'hA; man_b = 4'h6; man_op = 3'b011;
    while (got < 10) tick(1);
    do tick(1); while (!res_valid);
    ena = 0; snap = got;
    tick(40);
    chk(got == snap + 1, "R8 enable drop finishes step", got, snap + 1);
    chk(res_valid == 0, "R8 enable drop stops", res_valid, 0);
    ena = 1;
    ready_dly = 1; busy_len = 40;
    while (got < 16) tick(1);
    do tick(1); while (!res_valid);
    mode_cpu = 0; snap = got;
    tick(80);
    chk(got == snap + 1, "R8 mode drop finishes step", got, snap + 1);
    manual(9, 7, 0, 16);
    manual(2, 5, 1, 16'hFFFD);
    manual(15, 15, 2, 225);
    manual(13, 4, 3, 3);
    manual(13, 4, 4, 1);
    manual(7, 0, 3, 16'h00FF);
    manual(7, 0, 4, 7);
    manual(5, 5, 5, 1);
    manual(3, 9, 6, 0);
    manual(3, 9, 7, 1);
    manual(9, 3, 6, 1);
    tick(2);
    mode_cpu = 1; busy_len = 2; ready_dly = 0;
    while (got < 26) tick(1);
    chk(ext_got >= 48, "R12 alternate program wraps", ext_got, 48);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d results expected 26", got);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule